// File: doc/BRIEF.md
# Long-Word Cache Entry Filler for a Width-Reporting Bus

The filler sits between a processor cache and an asynchronous bus whose slave announces its data width on every cycle it ends. A read request carries an address, an operand size and a cachable flag. The filler runs a bus cycle for the requested operand first. When the read may be cached, it then runs as many more bus cycles as the slave's width requires to gather the remaining bytes of the aligned 32-bit long word, wrapping from the requested byte back to the long-word base. It writes the completed long word into the cache as one valid entry.

The operand is returned to the requester as soon as its own bytes have arrived, which may be before the cache entry is complete. A fill is abandoned without a cache write if the slave inhibits caching, signals a bus error, or reports a different width partway through the fill. Operands that cross a long-word boundary, burst fills, tag lookup and replacement are handled elsewhere.

Top module: `lwf_line_filler`

## Requirements
- R1: A request is taken only in a cycle where `req_ready` is high. The next cycle asserts `bus_strobe` and lowers `req_ready`. The first bus cycle uses the requested address, and its size code is the operand size: 1 = byte, 2 = word, 3 = three bytes, 0 = four bytes.
- R2: `bus_dack_n` is active low. 2'b00 ends a cycle as a 32-bit port, 2'b01 as a 16-bit port, 2'b10 as an 8-bit port, and 2'b11 means wait. While waiting, `bus_strobe`, `bus_addr` and `bus_siz` hold.
- R3: Byte offset k of the long word occupies `data[31-8k -: 8]` on `rsp_data` and `cw_data`. An 8-bit port returns its byte on `bus_data[31:24]`. A 16-bit port returns the aligned halfword holding the cycle address on `bus_data[31:16]`, with the lower offset on the upper byte.
- R4: A cachable read whose first cycle ends without cache-inhibit and without bus error fills the whole entry. Each next cycle addresses the first missing byte found by scanning upward from the current offset, wrapping at 3 to 0. Its size code is the number of missing bytes, with four written as 0. A byte read at offset 3 on an 8-bit port therefore runs offsets 3, 0, 1, 2 with codes 1, 3, 2, 1.
- R5: A byte read at offset 3 on a 16-bit port takes two cycles: offset 3 with code 1, then offset 0 with code 2.
- R6: When the first cycle ends as a 32-bit port, the entry is written after that single cycle.
- R7: A cache write is a one-cycle `cw_wr` pulse in the cycle after the final bus cycle ends. It carries `cw_index` equal to address bits [31:2] and the complete long word. It occurs only once all four bytes have been gathered.
- R8: The operand is returned with a one-cycle `rsp_valid` and `rsp_berr` low, in the cycle after the bus cycle that supplies its last byte. This comes before or in the same cycle as the cache write, never later.
- R9: A non-cachable request, or a first cycle ending with `bus_cinh` high, fetches only the operand bytes and produces no cache write.
- R10: A width differing from the first cycle's width on a later cycle abandons the fill with no cache write. The operand is still returned, and cycles continue only while operand bytes are missing.
- R11: `bus_berr` ends the transaction and blocks the cache write. If the operand has not yet been returned, `rsp_valid` pulses with `rsp_berr` high.
- R12: After reset, `bus_strobe`, `rsp_valid` and `cw_wr` are low and `req_ready` is high. `bus_strobe` is low for at least the cycle after every ending bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Filler idle, request may be taken |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size code |
| req_cachable | input | 1 | Request may be cached |
| rsp_valid | output | 1 | Operand returned (pulse) |
| rsp_berr | output | 1 | Operand ended in bus error |
| rsp_data | output | 32 | Long word with operand bytes in their lanes |
| bus_strobe | output | 1 | Bus cycle active |
| bus_addr | output | ADDR_W | Bus cycle byte address |
| bus_siz | output | 2 | Bytes still wanted (0 = four) |
| bus_dack_n | input | 2 | Active-low cycle end with port width |
| bus_data | input | 32 | Read data from the slave |
| bus_cinh | input | 1 | Slave forbids caching of this cycle |
| bus_berr | input | 1 | Bus error ending the cycle |
| cw_wr | output | 1 | Write one valid cache entry (pulse) |
| cw_index | output | ADDR_W-2 | Long-word index of the entry |
| cw_data | output | 32 | Entry data |

## Verification
The operand return and the cache entry write can fall in the same cycle. This happens when the single cycle of a 32-bit port supplies both, and also when the operand's last byte is the last byte of the fill. The 32-bit case is provoked with a byte request answered by a 32-bit acknowledge after wait states, and the cycle stamps of both pulses are compared for equality. The 8-bit fill is judged the other way: its response stamp must precede its write stamp.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

  typedef enum logic [1:0] {
    PW_8    = 2'd0,
    PW_16   = 2'd1,
    PW_32   = 2'd2,
    PW_NONE = 2'd3
  } port_w_e;

  // Active-low two-line acknowledge to port width
  function automatic port_w_e decode_dack(input logic [1:0] dn);
    case (dn)
      2'b00:   return PW_32;
      2'b01:   return PW_16;
      2'b10:   return PW_8;
      default: return PW_NONE;
    endcase
  endfunction

  // Lanes covered by an operand of size code sz at offset off (0 = four)
  function automatic logic [3:0] op_mask(input logic [1:0] off, input logic [1:0] sz);
    logic [3:0] m;
    int n;
    n = (sz == 2'd0) ? 4 : int'(sz);
    for (int i = 0; i < 4; i++)
      m[i] = (i >= int'(off)) && (i < int'(off) + n);
    return m;
  endfunction

endpackage

// File: rtl/lwf_lane_steer.sv
module lwf_lane_steer
  import lwf_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int OW    = $clog2(LANES)
) (
  input  logic [DW-1:0]    bus_dat,
  input  logic [OW-1:0]    off,
  input  port_w_e          pw,
  output logic [DW-1:0]    lanes,
  output logic [LANES-1:0] hit
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OW-1:0] IDX = OW'(i);
    logic              l_hit;
    logic [LANE_W-1:0] l_dat;

    always_comb begin
      case (pw)
        PW_8: begin
          l_hit = (off == IDX);
          l_dat = bus_dat[DW-1 -: LANE_W];
        end
        PW_16: begin
          l_hit = (off[OW-1:1] == IDX[OW-1:1]);
          l_dat = bus_dat[DW-1-LANE_W*(i%2) -: LANE_W];
        end
        PW_32: begin
          l_hit = 1'b1;
          l_dat = bus_dat[DW-1-LANE_W*i -: LANE_W];
        end
        default: begin
          l_hit = 1'b0;
          l_dat = '0;
        end
      endcase
    end

    assign hit[i] = l_hit;
    assign lanes[DW-1-LANE_W*i -: LANE_W] = l_dat;
  end

endmodule

// File: rtl/lwf_next_pick.sv
module lwf_next_pick #(
  parameter int LANES = 4,
  localparam int OW   = $clog2(LANES)
) (
  input  logic [LANES-1:0] rem,
  input  logic [OW-1:0]    cur,
  output logic [OW-1:0]    nxt,
  output logic [OW-1:0]    siz
);

  logic [OW-1:0] idx;
  logic          found;
  logic [OW:0]   cnt;

  always_comb begin
    nxt   = cur;
    found = 1'b0;
    idx   = cur;
    for (int k = 1; k <= LANES; k++) begin
      idx = cur + OW'(k);
      if (!found && rem[idx]) begin
        nxt   = idx;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < LANES; k++)
      cnt = cnt + (OW+1)'(rem[k]);
    siz = cnt[OW-1:0];
  end

endmodule

// File: rtl/lwf_line_filler.sv
module lwf_line_filler
  import lwf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int OW    = $clog2(LANES),
  localparam int IDX_W = ADDR_W - OW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OW-1:0]     req_size,
  input  logic              req_cachable,
  output logic              rsp_valid,
  output logic              rsp_berr,
  output logic [DW-1:0]     rsp_data,
  output logic              bus_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [OW-1:0]     bus_siz,
  input  logic [1:0]        bus_dack_n,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_cinh,
  input  logic              bus_berr,
  output logic              cw_wr,
  output logic [IDX_W-1:0]  cw_index,
  output logic [DW-1:0]     cw_data
);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_GAP} st_e;

  st_e               st;
  logic [IDX_W-1:0]  base_q;
  logic [OW-1:0]     off_q;
  logic [LANES-1:0]  got_q, opm_q;
  logic [DW-1:0]     data_q;
  logic              fill_q, first_q, opdone_q;
  port_w_e           width_q;

  logic              strobe_q, rsp_valid_q, rsp_berr_q, cw_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OW-1:0]     siz_q;
  logic [DW-1:0]     rsp_data_q, cw_data_q;
  logic [IDX_W-1:0]  cw_index_q;

  port_w_e           pw;
  logic [DW-1:0]     lanes;
  logic [LANES-1:0]  hit, got_n, need_n, rem_n;
  logic [DW-1:0]     data_n;
  logic              fill_n, op_full;
  logic [OW-1:0]     nxt, nsiz;

  assign pw = decode_dack(bus_dack_n);

  lwf_lane_steer #(.LANE_W(LANE_W), .LANES(LANES)) u_steer (
    .bus_dat (bus_data),
    .off     (off_q),
    .pw      (pw),
    .lanes   (lanes),
    .hit     (hit)
  );

  always_comb begin
    data_n = data_q;
    for (int i = 0; i < LANES; i++)
      if (hit[i]) data_n[DW-1-LANE_W*i -: LANE_W] = lanes[DW-1-LANE_W*i -: LANE_W];
  end

  assign got_n   = got_q | hit;
  assign fill_n  = fill_q && !bus_cinh && (first_q || pw == width_q);
  assign need_n  = fill_n ? '1 : opm_q;
  assign rem_n   = need_n & ~got_n;
  assign op_full = ((opm_q & ~got_n) == '0);

  lwf_next_pick #(.LANES(LANES)) u_pick (
    .rem (rem_n),
    .cur (off_q),
    .nxt (nxt),
    .siz (nsiz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      base_q      <= '0;
      off_q       <= '0;
      got_q       <= '0;
      opm_q       <= '0;
      data_q      <= '0;
      fill_q      <= 1'b0;
      first_q     <= 1'b0;
      opdone_q    <= 1'b0;
      width_q     <= PW_NONE;
      strobe_q    <= 1'b0;
      addr_q      <= '0;
      siz_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_berr_q  <= 1'b0;
      rsp_data_q  <= '0;
      cw_wr_q     <= 1'b0;
      cw_data_q   <= '0;
      cw_index_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      cw_wr_q     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            base_q   <= req_addr[ADDR_W-1:OW];
            off_q    <= req_addr[OW-1:0];
            opm_q    <= op_mask(req_addr[OW-1:0], req_size);
            got_q    <= '0;
            data_q   <= '0;
            fill_q   <= req_cachable;
            first_q  <= 1'b1;
            opdone_q <= 1'b0;
            strobe_q <= 1'b1;
            addr_q   <= req_addr;
            siz_q    <= req_size;
            st       <= S_BUS;
          end
        end
        S_BUS: begin
          if (bus_berr) begin
            strobe_q <= 1'b0;
            st       <= S_IDLE;
            if (!opdone_q) begin
              rsp_valid_q <= 1'b1;
              rsp_berr_q  <= 1'b1;
            end
          end else if (pw != PW_NONE) begin
            strobe_q <= 1'b0;
            got_q    <= got_n;
            data_q   <= data_n;
            fill_q   <= fill_n;
            first_q  <= 1'b0;
            if (first_q) width_q <= pw;
            if (op_full && !opdone_q) begin
              rsp_valid_q <= 1'b1;
              rsp_berr_q  <= 1'b0;
              rsp_data_q  <= data_n;
              opdone_q    <= 1'b1;
            end
            if (rem_n == '0) begin
              st <= S_IDLE;
              if (fill_n) begin
                cw_wr_q    <= 1'b1;
                cw_data_q  <= data_n;
                cw_index_q <= base_q;
              end
            end else begin
              st     <= S_GAP;
              off_q  <= nxt;
              addr_q <= {base_q, nxt};
              siz_q  <= nsiz;
            end
          end
        end
        S_GAP: begin
          strobe_q <= 1'b1;
          st       <= S_BUS;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_berr   = rsp_berr_q;
  assign rsp_data   = rsp_data_q;
  assign bus_strobe = strobe_q;
  assign bus_addr   = addr_q;
  assign bus_siz    = siz_q;
  assign cw_wr      = cw_wr_q;
  assign cw_index   = cw_index_q;
  assign cw_data    = cw_data_q;

endmodule

// File: rtl/lwf_line_filler_chk.sv
module lwf_line_filler_chk #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int OW    = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_berr,
  input logic              bus_strobe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [OW-1:0]     bus_siz,
  input logic [1:0]        bus_dack_n,
  input logic              bus_cinh,
  input logic              bus_berr,
  input logic              cw_wr
);

  // R1
  req_accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> bus_strobe && !req_ready);

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && bus_dack_n == 2'b11 && !bus_berr
    |=> bus_strobe && $stable(bus_addr) && $stable(bus_siz));

  // R12
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && (bus_dack_n != 2'b11 || bus_berr) |=> !bus_strobe);

  // R7
  write_src_chk: assert property (@(posedge clk) disable iff (rst)
    cw_wr |-> $past(bus_strobe && !bus_berr && !bus_cinh && bus_dack_n != 2'b11));

  // R11
  berr_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_berr |-> !cw_wr && $past(bus_berr));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

bind lwf_line_filler lwf_line_filler_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (.*);

// File: tb/test_lwf_line_filler.sv
module test_lwf_line_filler;

  localparam logic [31:0] MEMW = 32'hA1B2C3D4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_cachable = 1'b0;
  logic        rsp_valid, rsp_berr;
  logic [31:0] rsp_data;
  logic        bus_strobe;
  logic [31:0] bus_addr;
  logic [1:0]  bus_siz;
  logic [1:0]  bus_dack_n = 2'b11;
  logic [31:0] bus_data = '0;
  logic        bus_cinh = 1'b0;
  logic        bus_berr = 1'b0;
  logic        cw_wr;
  logic [29:0] cw_index;
  logic [31:0] cw_data;

  int checks = 0, errors = 0, cyc = 0;
  int ncyc, rsp_cnt, cw_cnt, rsp_cyc, cw_cyc;
  logic [1:0]  log_off [8];
  logic [1:0]  log_siz [8];
  logic [31:0] last_rsp, last_cw;
  logic        last_berr;
  logic [29:0] last_idx;

  lwf_line_filler i_lwf_line_filler (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) if (!rst) begin
    if (rsp_valid) begin rsp_cnt++; rsp_cyc = cyc; last_rsp = rsp_data; last_berr = rsp_berr; end
    if (cw_wr) begin cw_cnt++; cw_cyc = cyc; last_cw = cw_data; last_idx = cw_index; end
  end

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int o);
    return MEMW[31-8*o -: 8];
  endfunction

  task automatic begin_req(input logic [31:0] a, input logic [1:0] sz, input logic cach);
    ncyc = 0; rsp_cnt = 0; cw_cnt = 0; rsp_cyc = -1; cw_cyc = -1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_cachable = cach;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "ready low after accept", req_ready, 0);
    chk("R1", "strobe", bus_strobe, 1);
    chk("R1", "first addr", bus_addr, a);
    chk("R1", "first size", bus_siz, sz);
  endtask

  // dk: active-low width code; be: bus error; ci: cache inhibit
  task automatic serve(input logic [1:0] dk, input bit be, input bit ci, input int waits);
    int o;
    logic [31:0] a0;
    for (int g = 0; g < 50 && !bus_strobe; g++) @(negedge clk);
    log_off[ncyc] = bus_addr[1:0];
    log_siz[ncyc] = bus_siz;
    ncyc++;
    a0 = bus_addr;
    repeat (waits) @(negedge clk);
    if (waits > 0) begin
      chk("R2", "strobe held while waiting", bus_strobe, 1);
      chk("R2", "addr held while waiting", bus_addr, a0);
    end
    o = int'(bus_addr[1:0]);
    case (dk)
      2'b10:   bus_data = {byte_of(o), 24'h0};
      2'b01:   bus_data = {byte_of(o & 2), byte_of((o & 2) + 1), 16'h0};
      default: bus_data = MEMW;
    endcase
    bus_dack_n = be ? 2'b11 : dk;
    bus_berr = be;
    bus_cinh = ci;
    @(negedge clk);
    bus_dack_n = 2'b11; bus_berr = 1'b0; bus_cinh = 1'b0; bus_data = '0;
    chk("R12", "strobe low after cycle end", bus_strobe, 0);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12", "reset strobe", bus_strobe, 0);
    chk("R12", "reset ready", req_ready, 1);
    chk("R12", "reset rsp", rsp_valid, 0);
    chk("R12", "reset write", cw_wr, 0);
  endtask

  task automatic t_byte8_fill();
    begin_req(32'h0000_1233, 2'd1, 1'b1);
    repeat (4) serve(2'b10, 0, 0, 0);
    settle();
    chk("R4", "cycle count", ncyc, 4);
    chk("R4", "offsets", {log_off[0], log_off[1], log_off[2], log_off[3]}, 8'b11_00_01_10);
    chk("R4", "size codes", {log_siz[0], log_siz[1], log_siz[2], log_siz[3]}, 8'b01_11_10_01);
    chk("R3", "operand byte lane", last_rsp[7:0], 8'hD4);
    chk("R7", "write count", cw_cnt, 1);
    chk("R7", "entry data", last_cw, MEMW);
    chk("R7", "entry index", last_idx, 30'h0000_1233 >> 2);
    chk("R8", "rsp count", rsp_cnt, 1);
    chk("R8", "rsp before write", rsp_cyc < cw_cyc, 1);
  endtask

  task automatic t_byte16_fill();
    begin_req(32'h0000_2003, 2'd1, 1'b1);
    repeat (2) serve(2'b01, 0, 0, 0);
    settle();
    chk("R5", "cycle count", ncyc, 2);
    chk("R5", "offsets", {log_off[0], log_off[1]}, 4'b11_00);
    chk("R5", "sizes", {log_siz[0], log_siz[1]}, 4'b01_10);
    chk("R3", "halfword lanes", last_rsp[15:0], 16'hC3D4);
    chk("R5", "entry data", last_cw, MEMW);
    chk("R5", "write count", cw_cnt, 1);
  endtask

  task automatic t_long32_same_cycle();
    begin_req(32'h0000_3001, 2'd1, 1'b1);
    serve(2'b00, 0, 0, 2);
    settle();
    chk("R6", "single cycle", ncyc, 1);
    chk("R6", "write count", cw_cnt, 1);
    chk("R6", "entry data", last_cw, MEMW);
    chk("R8", "rsp and write same cycle", rsp_cyc == cw_cyc, 1);
    chk("R8", "rsp not error", last_berr, 0);
  endtask

  task automatic t_uncached();
    begin_req(32'h0000_4000, 2'd2, 1'b0);
    repeat (2) serve(2'b10, 0, 0, 0);
    settle();
    chk("R9", "uncached cycles", ncyc, 2);
    chk("R9", "uncached sizes", {log_siz[0], log_siz[1]}, 4'b10_01);
    chk("R9", "uncached operand", last_rsp[31:16], 16'hA1B2);
    chk("R9", "uncached no write", cw_cnt, 0);
    begin_req(32'h0000_4002, 2'd2, 1'b1);
    serve(2'b10, 0, 1, 0);
    serve(2'b10, 0, 0, 0);
    settle();
    chk("R9", "inhibit offsets", {log_off[0], log_off[1]}, 4'b10_11);
    chk("R9", "inhibit second size", log_siz[1], 1);
    chk("R9", "inhibit operand", last_rsp[15:0], 16'hC3D4);
    chk("R9", "inhibit no write", cw_cnt, 0);
  endtask

  task automatic t_width_change();
    begin_req(32'h0000_5003, 2'd1, 1'b1);
    serve(2'b10, 0, 0, 0);
    serve(2'b01, 0, 0, 0);
    settle();
    chk("R10", "stops after change", ncyc, 2);
    chk("R10", "no write", cw_cnt, 0);
    chk("R10", "operand given", rsp_cnt, 1);
    begin_req(32'h0000_5002, 2'd2, 1'b1);
    serve(2'b10, 0, 0, 0);
    serve(2'b01, 0, 0, 0);
    settle();
    chk("R10", "second cycle offset", log_off[1], 3);
    chk("R10", "second cycle size", log_siz[1], 3);
    chk("R10", "operand completes", last_rsp[15:0], 16'hC3D4);
    chk("R10", "operand count", rsp_cnt, 1);
    chk("R10", "no write after change", cw_cnt, 0);
  endtask

  task automatic t_berr();
    begin_req(32'h0000_6000, 2'd0, 1'b1);
    serve(2'b00, 1, 0, 0);
    settle();
    chk("R11", "first-cycle error reported", {rsp_cnt[7:0], 7'd0, last_berr}, 16'h0101);
    chk("R11", "no write", cw_cnt, 0);
    chk("R11", "one cycle", ncyc, 1);
    begin_req(32'h0000_6003, 2'd1, 1'b1);
    serve(2'b10, 0, 0, 0);
    serve(2'b10, 1, 0, 0);
    settle();
    chk("R11", "late error cycles", ncyc, 2);
    chk("R11", "late error operand clean", last_berr, 0);
    chk("R11", "late error rsp count", rsp_cnt, 1);
    chk("R11", "late error no write", cw_cnt, 0);
    chk("R11", "ready again", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte8_fill();
    t_byte16_fill();
    t_long32_same_cycle();
    t_uncached();
    t_width_change();
    t_berr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R12 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule